// File: doc/BRIEF.md
# PLL Control Register Bank with Masked Writes

This block holds the control settings of one on-chip PLL in five small registers and drives the decoded fields straight to the PLL. A write needs no read-modify-write: the upper half of every write word is a per-bit enable for the lower half. Software can change one field, or a single bit, without disturbing its neighbours.

The bank also reports the PLL output frequency. It multiplies the reference frequency by the feedback factor and divides by the product of the reference and output dividers. The division runs on a bit-serial divider. The result carries a valid flag that drops as soon as any input to the calculation changes. It rises again a fixed number of cycles later.

Top module: `pll_ctl_regbank`

## Requirements
- R1: Registers sit at byte offsets 0x00, 0x04, 0x08, 0x0C and 0x10. Fields: 0x00 holds output divider `od` [3:0] and reference divider `nr` [13:8]; 0x04 holds feedback `nf` [12:0]; 0x08 holds `bwadj` [11:0]; 0x0C holds bypass [0], power-down [1] and PLL reset [5]; 0x10 holds `mode` [1:0].
- R2: On a write, bit i (0..15) of the addressed register takes `wr_data[i]` only when `wr_data[i+16]` is 1; otherwise it keeps its value.
- R3: `rd_data[31:16]` always reads zero, and bits outside the defined fields always read zero, even after being written with a 1.
- R4: After reset, 0x0C reads 0x0001 (bypass set, power-down clear), and every divider field and `mode` read zero.
- R5: The outputs `od`, `nr`, `nf`, `bwadj`, `bypass`, `pwrdn`, `pll_rst` and `mode` always equal the stored fields.
- R6: With bypass clear, `freq_out` = floor(`ref_freq` × (nf+1) / ((nr+1) × (od+1))) once `freq_valid` is high.
- R7: With bypass set, `freq_out` equals `ref_freq` once `freq_valid` is high, whatever the divider fields hold.
- R8: `freq_valid` goes low in the same cycle that `nf`, `nr`, `od`, bypass or `ref_freq` changes. It goes high again exactly REF_W+15 rising edges after the edge that stored the change (47 at defaults).
- R9: `pll_en` is high exactly when the power-down bit is clear.
- R10: A write whose address has nonzero bits [1:0], or whose offset is above 0x10, changes no register. Such an address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for `addr` |
| addr | input | 5 | Byte address for both write and read |
| wr_data | input | 32 | [31:16] bit-enable mask, [15:0] data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| ref_freq | input | REF_W | Reference frequency |
| od | output | 4 | Output divider field |
| nr | output | 6 | Reference divider field |
| nf | output | 13 | Feedback multiplier field |
| bwadj | output | 12 | Bandwidth adjust field |
| bypass | output | 1 | Bypass control |
| pwrdn | output | 1 | Power-down control |
| pll_rst | output | 1 | PLL reset control |
| pll_en | output | 1 | PLL enabled status |
| mode | output | 2 | Mode-select field |
| freq_out | output | REF_W+14 | Computed output frequency |
| freq_valid | output | 1 | `freq_out` is current |

## Verification
The frequency path is driven with four divider patterns. A round-number case tells a correct multiply from a wrong field offset. An all-ones case at full reference width catches truncated widths. A unity-divider case catches off-by-one in the plus-one terms. A case with a remainder separates floor division from rounding.

Masked writes are tried with full, partial and empty masks. Telling a partial mask apart from a full one shows the bit-level gating. Bypass is checked with non-unity dividers, so a result that ignored bypass would differ. The latency is counted in edges, both after a register write and after a reference change alone.

// File: rtl/pll_ctl_regbank.sv
module pll_ctl_regbank #(
  parameter int REF_W = 32,
  parameter int PW    = REF_W + 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [4:0]       addr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [REF_W-1:0] ref_freq,
  output logic [3:0]       od,
  output logic [5:0]       nr,
  output logic [12:0]      nf,
  output logic [11:0]      bwadj,
  output logic             bypass,
  output logic             pwrdn,
  output logic             pll_rst,
  output logic             pll_en,
  output logic [1:0]       mode,
  output logic [PW-1:0]    freq_out,
  output logic             freq_valid
);
  localparam int NREG = 5;
  localparam int DV_W = 12;
  localparam int CW   = $clog2(PW + 1);

  function automatic logic [15:0] fmask(input int i);
    case (i)
      0:       return 16'h3F0F;
      1:       return 16'h1FFF;
      2:       return 16'h0FFF;
      3:       return 16'h0023;
      default: return 16'h0003;
    endcase
  endfunction

  function automatic logic [15:0] rstval(input int i);
    return (i == 3) ? 16'h0001 : 16'h0000;
  endfunction

  logic [2:0]  idx;
  logic        hit;
  logic [15:0] regs [NREG];

  assign idx = addr[4:2];
  assign hit = (addr[1:0] == 2'b00) && (idx < 3'(NREG));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= rstval(g);
      else if (wr_en && hit && idx == 3'(g))
        regs[g] <= (regs[g] & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16] & fmask(g));
    end
  end

  assign rd_data = hit ? {16'h0000, regs[idx]} : 32'h0;

  assign od      = regs[0][3:0];
  assign nr      = regs[0][13:8];
  assign nf      = regs[1][12:0];
  assign bwadj   = regs[2][11:0];
  assign bypass  = regs[3][0];
  assign pwrdn   = regs[3][1];
  assign pll_rst = regs[3][5];
  assign pll_en  = ~regs[3][1];
  assign mode    = regs[4][1:0];

  // snapshot of the operands the current result was computed from
  logic [REF_W-1:0] s_ref;
  logic [12:0]      s_nf;
  logic [5:0]       s_nr;
  logic [3:0]       s_od;
  logic             s_byp;
  logic             kick, busy, valid_q, changed, start;
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    quo;
  logic [DV_W-1:0]  rem, dvs;
  logic [DV_W:0]    trial, diff;
  logic             ge;

  assign changed = (s_ref != ref_freq) || (s_nf != nf) || (s_nr != nr) ||
                   (s_od != od) || (s_byp != bypass);
  assign start   = changed || kick;
  assign trial   = {rem, quo[PW-1]};
  assign diff    = trial - {1'b0, dvs};
  assign ge      = trial >= {1'b0, dvs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick     <= 1'b1;
      busy     <= 1'b0;
      valid_q  <= 1'b0;
      cnt      <= '0;
      quo      <= '0;
      rem      <= '0;
      dvs      <= '0;
      s_ref    <= '0;
      s_nf     <= '0;
      s_nr     <= '0;
      s_od     <= '0;
      s_byp    <= 1'b0;
      freq_out <= '0;
    end else if (start) begin
      kick    <= 1'b0;
      busy    <= 1'b1;
      valid_q <= 1'b0;
      cnt     <= CW'(PW);
      s_ref   <= ref_freq;
      s_nf    <= nf;
      s_nr    <= nr;
      s_od    <= od;
      s_byp   <= bypass;
      quo     <= PW'(ref_freq) * PW'({1'b0, nf} + 14'd1);
      dvs     <= DV_W'(({1'b0, nr} + 7'd1) * ({1'b0, od} + 5'd1));
      rem     <= '0;
    end else if (busy) begin
      rem <= ge ? diff[DV_W-1:0] : trial[DV_W-1:0];
      quo <= {quo[PW-2:0], ge};
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy     <= 1'b0;
        valid_q  <= 1'b1;
        freq_out <= s_byp ? PW'(s_ref) : {quo[PW-2:0], ge};
      end
    end
  end

  assign freq_valid = valid_q && !changed;
endmodule

module pll_ctl_regbank_chk #(
  parameter int REF_W = 32,
  parameter int PW    = REF_W + 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [4:0]       addr,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic [REF_W-1:0] ref_freq,
  input logic [3:0]       od,
  input logic [5:0]       nr,
  input logic [12:0]      nf,
  input logic [11:0]      bwadj,
  input logic             bypass,
  input logic             pwrdn,
  input logic             pll_rst,
  input logic             pll_en,
  input logic [1:0]       mode,
  input logic [PW-1:0]    freq_out,
  input logic             freq_valid
);
  assert_zero_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'h04 && wr_data[31:16] == 16'h0) |=> $stable(nf));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:16] == 16'h0);

  assert_bypass_freq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_valid && bypass) |-> freq_out == PW'(ref_freq));

  assert_change_drops_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(nf) || !$stable(nr) || !$stable(od) || !$stable(ref_freq)) |-> !freq_valid);

  assert_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en == !pwrdn);

  assert_bad_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] != 2'b00) |=> ($stable(mode) && $stable(bypass) && $stable(pwrdn) &&
                                       $stable(nf) && $stable(bwadj) && $stable(pll_rst)));
endmodule

bind pll_ctl_regbank pll_ctl_regbank_chk #(.REF_W(REF_W), .PW(PW)) chk_i (.*);

// File: tb/pll_ctl_regbank_tb.sv
`timescale 1ns/1ps
module pll_ctl_regbank_tb_top;
  localparam int REF_W = 32;
  localparam int PW    = REF_W + 14;
  localparam int LAT   = REF_W + 15;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [REF_W-1:0] ref_freq = 32'd24_000_000;
  logic [3:0] od; logic [5:0] nr; logic [12:0] nf; logic [11:0] bwadj;
  logic bypass, pwrdn, pll_rst, pll_en, freq_valid;
  logic [1:0] mode;
  logic [PW-1:0] freq_out;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pll_ctl_regbank #(.REF_W(REF_W)) dut_i (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rd_data;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!freq_valid && n < 500) begin @(posedge clk); #1; n++; end
  endtask

  function automatic longint expf(longint r, longint f, longint m, longint o);
    return (r * (f + 1)) / ((m + 1) * (o + 1));
  endfunction

  task automatic t_reset;
    logic [31:0] d; int n;
    rd(5'h0C, d); check(d == 32'h1, "R4 reg3 reset", d, 1);
    rd(5'h00, d); check(d == 0, "R4 reg0 reset", d, 0);
    rd(5'h10, d); check(d == 0, "R4 mode reset", d, 0);
    check(pll_en == 1, "R9 enabled at reset", pll_en, 1);
    wait_valid(n);
    check(freq_valid && freq_out == PW'(ref_freq), "R7 reset bypass freq", freq_out, ref_freq);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr(5'h00, 32'hFFFF_0101);
    wr(5'h04, 32'hFFFF_0063);
    wr(5'h08, 32'hFFFF_0ABC);
    rd(5'h00, d); check(d == 32'h0101, "R1 reg0 readback", d, 32'h0101);
    check(od == 1 && nr == 1, "R5 od/nr decode", {nr, od}, {6'd1, 4'd1});
    check(nf == 99, "R5 nf decode", nf, 99);
    check(bwadj == 12'hABC, "R5 bwadj decode", bwadj, 12'hABC);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    wr(5'h08, 32'h00F0_0F5F);
    check(bwadj == 12'hA5C, "R2 partial mask", bwadj, 12'hA5C);
    wr(5'h04, 32'h0000_1234);
    check(nf == 99, "R2 empty mask", nf, 99);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d); check(d == 32'h3F0F, "R3 unused bits zero", d, 32'h3F0F);
    wr(5'h00, 32'hFFFF_0101);
    rd(5'h00, d); check(d[31:16] == 0, "R3 upper half zero", d, 0);
  endtask

  task automatic t_freq;
    int n; longint e;
    wr(5'h0C, 32'h0001_0000);
    check(bypass == 0 && !freq_valid, "R8 valid drops on change", freq_valid, 0);
    wait_valid(n);
    check(n == LAT, "R8 latency", n, LAT);
    check(freq_out == 600_000_000, "R6 pattern round", freq_out, 600_000_000);

    ref_freq = 32'hFFFF_FFFF;
    wr(5'h00, 32'hFFFF_3F0F); wr(5'h04, 32'hFFFF_1FFF);
    wait_valid(n); e = expf(32'hFFFF_FFFF, 8191, 63, 15);
    check(freq_out == PW'(e), "R6 pattern all-ones", freq_out, e);

    ref_freq = 32'd1_000_003;
    wr(5'h00, 32'hFFFF_0000); wr(5'h04, 32'hFFFF_0000);
    wait_valid(n);
    check(freq_out == 1_000_003, "R6 pattern unity", freq_out, 1_000_003);

    wr(5'h00, 32'hFFFF_0200); wr(5'h04, 32'hFFFF_0006);
    wait_valid(n); e = expf(1_000_003, 6, 2, 0);
    check(freq_out == PW'(e), "R6 pattern remainder", freq_out, e);
  endtask

  task automatic t_bypass_ref;
    int n;
    wr(5'h0C, 32'h0001_0001);
    wait_valid(n);
    check(freq_out == 1_000_003, "R7 bypass with dividers", freq_out, 1_000_003);
    wr(5'h0C, 32'h0001_0000);
    wait_valid(n);
    @(negedge clk); ref_freq = 32'd3_000_000; #0.5;
    check(!freq_valid, "R8 ref change drops valid", freq_valid, 0);
    wait_valid(n);
    check(n == LAT && freq_out == PW'(expf(3_000_000, 6, 2, 0)), "R8 ref change result", freq_out, expf(3_000_000, 6, 2, 0));
  endtask

  task automatic t_ctrl;
    wr(5'h0C, 32'h0022_0022);
    check(pwrdn == 1 && pll_rst == 1, "R5 pwrdn/reset decode", {pwrdn, pll_rst}, 2'b11);
    check(pll_en == 0, "R9 disabled", pll_en, 0);
    wr(5'h0C, 32'h0002_0000);
    check(pll_en == 1, "R9 re-enabled", pll_en, 1);
    wr(5'h10, 32'h0003_0002);
    check(mode == 2, "R1 mode write", mode, 2);
    wr(5'h10, 32'h0001_0001);
    check(mode == 3, "R2 mode partial", mode, 3);
  endtask

  task automatic t_badaddr;
    logic [31:0] d;
    wr(5'h0D, 32'hFFFF_0000);
    rd(5'h0C, d); check(d == 32'h0020, "R10 misaligned ignored", d, 32'h0020);
    wr(5'h12, 32'hFFFF_0000);
    check(mode == 3, "R10 misaligned mode", mode, 3);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, d); check(d == 0, "R10 out of range reads zero", d, 0);
    check(mode == 3 && bwadj == 12'hA5C, "R10 out of range ignored", bwadj, 12'hA5C);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fields;
    t_masked;
    t_freq;
    t_bypass_ref;
    t_ctrl;
    t_badaddr;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule